// File: doc/BRIEF.md
# Memory Range Decoder with Gap

This block sits in front of one memory controller and decides, for every physical address, whether that controller owns the access and whether the access may proceed. Addresses are 36 bits wide (up to 64 GB). The controller's memory is seen as a window running from a programmable base to a programmable limit. A programmable hole, given as a low edge and a high edge, can split that window into a lower range and an upper range. Several controllers can each hold their own window with no need for the windows to be adjacent.

Inside the first megabyte, each of sixteen 64 KB subregions carries a 2-bit access attribute that can block reads, writes or both. An access that lands in owned memory but breaks its subregion's attribute is still claimed by this controller and is flagged as not permitted.

For upper-range hits the block also produces a compressed local offset: the hole is removed, so the DRAM behind the controller is filled with no unused space. The decode is combinational, with a parameter-selected output register. The default is registered, with one cycle of latency.

Top module: `mem_range_dec`

## Requirements
- R1: With the output register enabled (default), the outputs reflect the address, strobe and configuration sampled at the previous rising clock edge, and a synchronous active-high reset drives hit, permitted and offset to zero.
- R2: When the gap is enabled (gap_high greater than gap_low), an address in [base, gap_low) is a hit with offset equal to address minus base.
- R3: When the gap is enabled, an address in [gap_low, gap_high) is never a hit.
- R4: When the gap is enabled, an address in [gap_high, limit) is a hit with offset equal to address minus base minus (gap_high minus gap_low), modulo 2^36.
- R5: When gap_high is not greater than gap_low, the gap is disabled: every address in [base, limit) is a hit with offset equal to address minus base.
- R6: An address below base, or at or above limit, is not a hit.
- R7: Below 0x10_0000 the space is cut into 16 subregions of 64 KB, selected by address bits [19:16]; subregion i takes its attribute from attr bits [2i+1:2i]. Attribute bit 0 allows reads and bit 1 allows writes: 00 disabled, 01 read-only, 10 write-only, 11 read/write.
- R8: Permitted is never set without hit; a hit whose access breaks its subregion attribute gives hit=1 and permitted=0.
- R9: At or above 0x10_0000, every hit is permitted, for both reads and writes.
- R10: When hit is 0, permitted is 0 and offset is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 36 | Physical address of the access |
| wr_i | input | 1 | Access type: 1 = write, 0 = read |
| base_i | input | 36 | Inclusive bottom of the controller's window |
| limit_i | input | 36 | Exclusive top of the controller's window |
| gap_low_i | input | 36 | Exclusive top of the lower range (bottom of the hole) |
| gap_high_i | input | 36 | Inclusive bottom of the upper range (top of the hole) |
| attr_i | input | 32 | Sixteen 2-bit attributes for the first megabyte |
| hit_o | output | 1 | This controller owns the address |
| permit_o | output | 1 | The access is allowed |
| offset_o | output | 36 | Gap-compressed local memory offset |

## Verification
The assertions check several behaviours on every cycle, one cycle after the inputs: addresses inside an enabled hole and addresses at or above the limit never hit, a disabled subregion never grants permission, permission never appears without a hit, a miss carries a zero offset, and any hit above the first megabyte is permitted. The bench's scenarios cover the rest. These are the exact offset arithmetic at the range edges and across the hole, the collapse to a single range when the gap edges are equal, a non-zero base, and the read/write result for each of the four attribute codes. They also show the reset state and the single-cycle latency.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

    // Access attribute of one low-megabyte subregion: bit0 = read ok, bit1 = write ok
    typedef enum logic [1:0] {
        ATTR_OFF = 2'b00,
        ATTR_RO  = 2'b01,
        ATTR_WO  = 2'b10,
        ATTR_RW  = 2'b11
    } attr_e;

    // Range classification produced by the window comparator
    typedef struct packed {
        logic gap_en;
        logic in_lower;
        logic in_upper;
    } range_t;

    function automatic logic attr_allows(attr_e a, logic is_wr);
        logic ok;
        case (a)
            ATTR_RW:  ok = 1'b1;
            ATTR_RO:  ok = ~is_wr;
            ATTR_WO:  ok = is_wr;
            default:  ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/mrd_window.sv
module mrd_window
    import mrd_pkg::*;
#(
    parameter int ADDR_W = 36
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    input  logic [ADDR_W-1:0] gap_low,
    input  logic [ADDR_W-1:0] gap_high,
    output logic              hit,
    output logic [ADDR_W-1:0] offset
);
    range_t             rng;
    logic               above_base;
    logic               below_limit;
    logic [ADDR_W-1:0]  gap_size;
    logic [ADDR_W-1:0]  rel;

    always_comb begin
        above_base   = (addr >= base);
        below_limit  = (addr < limit);
        rng.gap_en   = (gap_high > gap_low);
        if (rng.gap_en) begin
            rng.in_lower = above_base && (addr < gap_low) && below_limit;
            rng.in_upper = above_base && (addr >= gap_high) && below_limit;
        end else begin
            rng.in_lower = above_base && below_limit;
            rng.in_upper = 1'b0;
        end
        gap_size = rng.gap_en ? (gap_high - gap_low) : '0;
        rel      = addr - base;
        hit      = rng.in_lower | rng.in_upper;
        if (!hit)
            offset = '0;
        else if (rng.in_upper)
            offset = rel - gap_size;
        else
            offset = rel;
    end

endmodule

// File: rtl/mrd_attr.sv
module mrd_attr
    import mrd_pkg::*;
#(
    parameter int ADDR_W   = 36,
    parameter int SUBREG_N = 16,
    parameter int SUB_BITS = 16
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  is_wr,
    input  logic [2*SUBREG_N-1:0] attr,
    output logic                  allow
);
    localparam int IDX_W = (SUBREG_N > 1) ? $clog2(SUBREG_N) : 1;
    localparam logic [ADDR_W-1:0] LOW_TOP = ADDR_W'(SUBREG_N) << SUB_BITS;

    attr_e            slot_attr [SUBREG_N];
    logic [IDX_W-1:0] idx;
    logic             in_low_mb;

    for (genvar g = 0; g < SUBREG_N; g++) begin : g_slot
        assign slot_attr[g] = attr_e'(attr[2*g +: 2]);
    end

    always_comb begin
        in_low_mb = (addr < LOW_TOP);
        idx       = addr[SUB_BITS +: IDX_W];
        allow     = in_low_mb ? attr_allows(slot_attr[idx], is_wr) : 1'b1;
    end

endmodule

// File: rtl/mrd_out_stage.sv
module mrd_out_stage #(
    parameter int ADDR_W  = 36,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit_d,
    input  logic              permit_d,
    input  logic [ADDR_W-1:0] offset_d,
    output logic              hit_q,
    output logic              permit_q,
    output logic [ADDR_W-1:0] offset_q
);
    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                hit_q    <= 1'b0;
                permit_q <= 1'b0;
                offset_q <= '0;
            end else begin
                hit_q    <= hit_d;
                permit_q <= permit_d;
                offset_q <= offset_d;
            end
        end
    end else begin : g_comb
        assign hit_q    = hit_d;
        assign permit_q = permit_d;
        assign offset_q = offset_d;
    end

endmodule

// File: rtl/mem_range_dec.sv
module mem_range_dec
    import mrd_pkg::*;
#(
    parameter int ADDR_W   = 36,
    parameter int SUBREG_N = 16,
    parameter int SUB_BITS = 16,
    parameter bit OUT_REG  = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  wr_i,
    input  logic [ADDR_W-1:0]     base_i,
    input  logic [ADDR_W-1:0]     limit_i,
    input  logic [ADDR_W-1:0]     gap_low_i,
    input  logic [ADDR_W-1:0]     gap_high_i,
    input  logic [2*SUBREG_N-1:0] attr_i,
    output logic                  hit_o,
    output logic                  permit_o,
    output logic [ADDR_W-1:0]     offset_o
);
    localparam int IDX_W = (SUBREG_N > 1) ? $clog2(SUBREG_N) : 1;
    localparam logic [ADDR_W-1:0] LOW_TOP = ADDR_W'(SUBREG_N) << SUB_BITS;

    logic              win_hit;
    logic [ADDR_W-1:0] win_off;
    logic              attr_ok;
    logic              permit_d;

    mrd_window #(.ADDR_W(ADDR_W)) u_window (
        .addr     (addr_i),
        .base     (base_i),
        .limit    (limit_i),
        .gap_low  (gap_low_i),
        .gap_high (gap_high_i),
        .hit      (win_hit),
        .offset   (win_off)
    );

    mrd_attr #(
        .ADDR_W   (ADDR_W),
        .SUBREG_N (SUBREG_N),
        .SUB_BITS (SUB_BITS)
    ) u_attr (
        .addr  (addr_i),
        .is_wr (wr_i),
        .attr  (attr_i),
        .allow (attr_ok)
    );

    assign permit_d = win_hit & attr_ok;

    mrd_out_stage #(.ADDR_W(ADDR_W), .OUT_REG(OUT_REG)) u_out (
        .clk      (clk),
        .rst      (rst),
        .hit_d    (win_hit),
        .permit_d (permit_d),
        .offset_d (win_off),
        .hit_q    (hit_o),
        .permit_q (permit_o),
        .offset_q (offset_o)
    );

    // Checks on the registered outputs against the inputs one cycle earlier
    if (OUT_REG) begin : g_chk
        logic [1:0] cur_slot;
        assign cur_slot = attr_i[{addr_i[SUB_BITS +: IDX_W], 1'b0} +: 2];

        a_r8_permit_needs_hit: assert property (@(posedge clk) disable iff (rst)
            permit_o |-> hit_o);

        a_r3_hole_never_hits: assert property (@(posedge clk) disable iff (rst)
            (gap_high_i > gap_low_i && addr_i >= gap_low_i && addr_i < gap_high_i)
            |=> !hit_o);

        a_r6_limit_never_hits: assert property (@(posedge clk) disable iff (rst)
            (addr_i >= limit_i) |=> !hit_o);

        a_r7_disabled_slot_denies: assert property (@(posedge clk) disable iff (rst)
            (addr_i < LOW_TOP && cur_slot == 2'b00) |=> !permit_o);

        a_r10_miss_zero_offset: assert property (@(posedge clk) disable iff (rst)
            !hit_o |-> (offset_o == '0 && !permit_o));

        a_r9_high_hit_permitted: assert property (@(posedge clk) disable iff (rst)
            (addr_i >= LOW_TOP && addr_i >= base_i && addr_i < limit_i &&
             !(gap_high_i > gap_low_i && addr_i >= gap_low_i && addr_i < gap_high_i))
            |=> (hit_o && permit_o));
    end

endmodule

// File: tb/mem_range_dec_tb.sv
module mem_range_dec_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [35:0] addr_i, base_i, limit_i, gap_low_i, gap_high_i;
    logic        wr_i;
    logic [31:0] attr_i;
    logic        hit_o, permit_o;
    logic [35:0] offset_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    mem_range_dec dut_i (
        .clk(clk), .rst(rst), .addr_i(addr_i), .wr_i(wr_i),
        .base_i(base_i), .limit_i(limit_i), .gap_low_i(gap_low_i),
        .gap_high_i(gap_high_i), .attr_i(attr_i),
        .hit_o(hit_o), .permit_o(permit_o), .offset_o(offset_o)
    );

    // Drive at the falling edge, let one rising edge register it, sample at the next falling edge
    task automatic access(input logic [35:0] a, input logic w);
        @(negedge clk);
        addr_i = a;
        wr_i   = w;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic eh, input logic ep,
                              input logic [35:0] eo);
        n_checks++;
        if (hit_o !== eh || permit_o !== ep || offset_o !== eo) begin
            n_fail++;
            $display("FAIL %s: got hit=%0b permit=%0b off=%h, expected hit=%0b permit=%0b off=%h",
                     req, hit_o, permit_o, offset_o, eh, ep, eo);
        end
    endtask

    task automatic set_cfg(input logic [35:0] b, input logic [35:0] l,
                           input logic [35:0] gl, input logic [35:0] gh);
        @(negedge clk);
        base_i = b; limit_i = l; gap_low_i = gl; gap_high_i = gh;
    endtask

    task automatic t_reset;
        @(negedge clk);
        addr_i = 36'h0_0001_0000; wr_i = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        expect_out("R1 reset", 1'b0, 1'b0, 36'h0);
        rst = 1'b0;
    endtask

    task automatic t_latency;
        // Output changes only after the rising edge that follows the new address
        @(negedge clk);
        addr_i = 36'h0_0050_0000; wr_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        addr_i = 36'h8_0000_0000;
        #1;
        expect_out("R1 latency", 1'b1, 1'b1, 36'h0_0050_0000);
        @(posedge clk);
        @(negedge clk);
        expect_out("R1 latency next", 1'b0, 1'b0, 36'h0);
    endtask

    task automatic t_lower;
        access(36'h0_0000_0000, 1'b0); expect_out("R2 lower at base", 1'b1, 1'b1, 36'h0);
        access(36'h0_7FFF_FFFF, 1'b1); expect_out("R2 lower top", 1'b1, 1'b1, 36'h0_7FFF_FFFF);
    endtask

    task automatic t_gap;
        access(36'h0_8000_0000, 1'b0); expect_out("R3 gap bottom", 1'b0, 1'b0, 36'h0);
        access(36'h0_FFFF_FFFF, 1'b1); expect_out("R3 gap top", 1'b0, 1'b0, 36'h0);
    endtask

    task automatic t_upper;
        access(36'h1_0000_0000, 1'b0); expect_out("R4 upper base", 1'b1, 1'b1, 36'h0_8000_0000);
        access(36'h1_2345_6780, 1'b1); expect_out("R4 upper mid", 1'b1, 1'b1, 36'h0_A345_6780);
        access(36'h1_FFFF_FFFF, 1'b0); expect_out("R4 upper top", 1'b1, 1'b1, 36'h1_7FFF_FFFF);
    endtask

    task automatic t_limit;
        access(36'h2_0000_0000, 1'b0); expect_out("R6 at limit", 1'b0, 1'b0, 36'h0);
        access(36'hF_FFFF_FFFF, 1'b1); expect_out("R6 top of space", 1'b0, 1'b0, 36'h0);
    endtask

    task automatic t_attr;
        // slot0 RW, slot1 RO, slot2 WO, slot3 disabled
        access(36'h0_0000_1234, 1'b1); expect_out("R7 RW write", 1'b1, 1'b1, 36'h0_0000_1234);
        access(36'h0_0001_0000, 1'b0); expect_out("R7 RO read", 1'b1, 1'b1, 36'h0_0001_0000);
        access(36'h0_0001_FFFF, 1'b1); expect_out("R8 RO write denied", 1'b1, 1'b0, 36'h0_0001_FFFF);
        access(36'h0_0002_0010, 1'b0); expect_out("R8 WO read denied", 1'b1, 1'b0, 36'h0_0002_0010);
        access(36'h0_0002_0010, 1'b1); expect_out("R7 WO write", 1'b1, 1'b1, 36'h0_0002_0010);
        access(36'h0_0003_0000, 1'b0); expect_out("R8 OFF read denied", 1'b1, 1'b0, 36'h0_0003_0000);
        access(36'h0_0003_0000, 1'b1); expect_out("R8 OFF write denied", 1'b1, 1'b0, 36'h0_0003_0000);
        access(36'h0_000F_FFFF, 1'b1); expect_out("R7 slot15 RW", 1'b1, 1'b1, 36'h0_000F_FFFF);
    endtask

    task automatic t_high_mb;
        // Even with every slot disabled, accesses from 1 MB up are allowed
        @(negedge clk); attr_i = 32'h0;
        access(36'h0_0010_0000, 1'b1); expect_out("R9 first byte above 1MB", 1'b1, 1'b1, 36'h0_0010_0000);
        access(36'h0_000F_FFFF, 1'b0); expect_out("R8 all disabled", 1'b1, 1'b0, 36'h0_000F_FFFF);
        @(negedge clk); attr_i = 32'hFFFF_FF27;
    endtask

    task automatic t_no_gap;
        set_cfg(36'h0, 36'h2_0000_0000, 36'h0_8000_0000, 36'h0_8000_0000);
        access(36'h0_9000_0000, 1'b0); expect_out("R5 equal edges", 1'b1, 1'b1, 36'h0_9000_0000);
        set_cfg(36'h0, 36'h2_0000_0000, 36'h1_0000_0000, 36'h0_8000_0000);
        access(36'h1_8000_0000, 1'b1); expect_out("R5 inverted edges", 1'b1, 1'b1, 36'h1_8000_0000);
    endtask

    task automatic t_base;
        set_cfg(36'h0_4000_0000, 36'h0_C000_0000, 36'h0_6000_0000, 36'h0_8000_0000);
        access(36'h0_3FFF_FFFF, 1'b0); expect_out("R6 below base", 1'b0, 1'b0, 36'h0);
        access(36'h0_4000_0010, 1'b0); expect_out("R2 base offset", 1'b1, 1'b1, 36'h0_0000_0010);
        access(36'h0_8000_0020, 1'b1); expect_out("R4 base and gap", 1'b1, 1'b1, 36'h0_2000_0020);
        access(36'h0_7000_0000, 1'b0); expect_out("R10 miss in hole", 1'b0, 1'b0, 36'h0);
    endtask

    initial begin
        rst = 1'b1;
        addr_i = '0; wr_i = 1'b0;
        base_i = 36'h0; limit_i = 36'h2_0000_0000;
        gap_low_i = 36'h0_8000_0000; gap_high_i = 36'h1_0000_0000;
        attr_i = 32'hFFFF_FF27;
        repeat (3) @(posedge clk);
        t_reset;
        t_latency;
        t_lower;
        t_gap;
        t_upper;
        t_limit;
        t_attr;
        t_high_mb;
        t_no_gap;
        t_base;
        done = 1'b1;
    end

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
            wait (done);
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule